// File: doc/BRIEF.md
# Two-Source Indexed Vector Shuffle

This block performs a table-lookup permutation on 128-bit vectors. Two source vectors, `src_j` and `src_k`, are joined into one table that holds twice as many elements as a single vector. Each element of the result is copied from that table. The table position for each element comes from the matching element of an index vector. The element width is 8, 16, 32 or 64 bits and is chosen per operation.

The caller places the index vector on `idx_vec`. For byte shuffles the index vector is a separate operand. For the wider widths it is the old contents of the destination register. The surrounding datapath does this routing. It reads all operands before the destination is written back, so every result element comes from pre-operation values. The block reports which kind of index source the selected width implies on `out_idx_from_dest`.

The result is registered and appears one cycle after `in_valid`. It is held until the next valid operation.

Top module: `vsel_shuffle`

## Requirements
- R1: While `rst` is high, `out_valid`, `out_idx_from_dest` and `result` are all cleared to 0 at the next clock edge.
- R2: `out_valid` is high in the cycle after `in_valid` was high, and low in the cycle after `in_valid` was low. `result` holds the outcome of the operation presented one cycle earlier.
- R3: While `in_valid` is low, `result` and `out_idx_from_dest` keep their previous values.
- R4: For each element, the raw index is the low 8 bits of that element of `idx_vec`, read as unsigned. The raw index is reduced modulo 2N, where N = 128 / width. Bits above the low byte of an element have no effect on the result.
- R5: When the reduced index k is less than N, result element i equals element k of `src_k`. Element e of a vector occupies bits [e*W +: W], where W is the element width.
- R6: When the reduced index k is N or more, result element i equals element k-N of `src_j`.
- R7: `elem_size` = 0 selects byte mode: 16 elements, indices taken modulo 32, and the index for element i is byte i of `idx_vec`.
- R8: `elem_size` = 1 selects 16-bit mode: 8 elements, indices modulo 16, and the index is the low byte of each 16-bit element of `idx_vec`.
- R9: `elem_size` = 2 selects 32-bit mode: 4 elements, indices modulo 8.
- R10: `elem_size` = 3 selects 64-bit mode: 2 elements, indices modulo 4.
- R11: On a valid operation, `out_idx_from_dest` becomes 0 for byte mode and 1 for the 16-, 32- and 64-bit modes. This marks the index vector as a separate operand or as the old destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| elem_size | input | 2 | Element width: 0=8, 1=16, 2=32, 3=64 bits |
| src_j | input | 128 | First source; supplies the upper half of the table |
| src_k | input | 128 | Second source; supplies the lower half of the table |
| idx_vec | input | 128 | Per-element indices (fourth operand or old destination) |
| out_valid | output | 1 | Result register holds a new result |
| out_idx_from_dest | output | 1 | 1 when the width mode takes its indices from the old destination |
| result | output | 128 | Registered shuffle result |

## Verification
Every width is swept with index bytes that pass through all 256 values in each lane. Wrap-around beyond 2N, the k = N boundary and every upper index bit are all covered. A design that masks too few or too many index bits would pick the wrong element for large raw values. A design that swaps the table halves would return `src_j` data where `src_k` data is expected. Random garbage is placed above each element's index byte, so a design that reads a wider index field would diverge. Idle cycles between operations would expose a result register that does not hold, or a valid flag that does not drop.

// File: rtl/vshuf_pkg.sv
package vshuf_pkg;
  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } elem_size_e;

  localparam int NSIZE = 4;
  localparam int IDX_BITS = 8;

  function automatic int elem_width(input int sel);
    return 8 << sel;
  endfunction
endpackage

// File: rtl/vshuf_lane_table.sv
module vshuf_lane_table #(
  parameter int VEC_W = 128,
  parameter int EW    = 8,
  localparam int N    = VEC_W / EW,
  localparam int IB   = vshuf_pkg::IDX_BITS
) (
  input  logic [VEC_W-1:0] src_j,
  input  logic [VEC_W-1:0] src_k,
  input  logic [N*IB-1:0]  idx_bytes,
  output logic [VEC_W-1:0] lanes
);
  localparam int TN = 2 * N;
  localparam int KW = $clog2(TN);
  localparam logic [IB:0] MODV = (IB+1)'(TN);

  logic [EW-1:0] tbl [TN];

  genvar t, e;
  generate
    for (t = 0; t < N; t++) begin : g_fill
      assign tbl[t]     = src_k[t*EW +: EW];
      assign tbl[t + N] = src_j[t*EW +: EW];
    end
    for (e = 0; e < N; e++) begin : g_lane
      logic [IB-1:0] raw;
      logic [KW-1:0] kidx;
      assign raw  = idx_bytes[e*IB +: IB];
      assign kidx = KW'({1'b0, raw} % MODV);
      assign lanes[e*EW +: EW] = tbl[kidx];
    end
  endgenerate
endmodule

// File: rtl/vshuf_size_mux.sv
module vshuf_size_mux #(
  parameter int VEC_W = 128,
  localparam int NS   = vshuf_pkg::NSIZE
) (
  input  logic [NS-1:0][VEC_W-1:0] cand,
  input  logic [1:0]               sel,
  output logic [VEC_W-1:0]         pick
);
  import vshuf_pkg::*;
  always_comb begin
    case (elem_size_e'(sel))
      SZ_B:    pick = cand[0];
      SZ_H:    pick = cand[1];
      SZ_W:    pick = cand[2];
      default: pick = cand[3];
    endcase
  end
endmodule

// File: rtl/vsel_shuffle.sv
module vsel_shuffle #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       elem_size,
  input  logic [VEC_W-1:0] src_j,
  input  logic [VEC_W-1:0] src_k,
  input  logic [VEC_W-1:0] idx_vec,
  output logic             out_valid,
  output logic             out_idx_from_dest,
  output logic [VEC_W-1:0] result
);
  import vshuf_pkg::*;
  localparam int IB = IDX_BITS;

  logic [NSIZE-1:0][VEC_W-1:0] cand;
  logic [VEC_W-1:0]            picked;

  genvar s, e;
  generate
    for (s = 0; s < NSIZE; s++) begin : g_size
      localparam int EW = 8 << s;
      localparam int N  = VEC_W / EW;
      logic [N*IB-1:0] ib;
      for (e = 0; e < N; e++) begin : g_ib
        assign ib[e*IB +: IB] = idx_vec[e*EW +: IB];
      end
      vshuf_lane_table #(.VEC_W(VEC_W), .EW(EW)) u_tbl (
        .src_j     (src_j),
        .src_k     (src_k),
        .idx_bytes (ib),
        .lanes     (cand[s])
      );
    end
  endgenerate

  vshuf_size_mux #(.VEC_W(VEC_W)) u_mux (
    .cand (cand),
    .sel  (elem_size),
    .pick (picked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid         <= 1'b0;
      out_idx_from_dest <= 1'b0;
      result            <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result            <= picked;
        out_idx_from_dest <= (elem_size_e'(elem_size) != SZ_B);
      end
    end
  end
endmodule

// File: rtl/vsel_shuffle_chk.sv
module vsel_shuffle_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       elem_size,
  input logic [VEC_W-1:0] src_j,
  input logic [VEC_W-1:0] src_k,
  input logic [VEC_W-1:0] idx_vec,
  input logic             out_valid,
  input logic             out_idx_from_dest,
  input logic [VEC_W-1:0] result
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_idx_from_dest && result == '0));

  a_r2_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_valid_drop: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(out_idx_from_dest)));

  a_r11_mode_bit: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_idx_from_dest == ($past(elem_size) != 2'd0)));

  a_r5_byte_lane0: assert property (@(posedge clk) disable iff (rst)
    (in_valid && elem_size == 2'd0 && idx_vec[4:0] == 5'd0)
      |=> (result[7:0] == $past(src_k[7:0])));

  a_r10_dw_top: assert property (@(posedge clk) disable iff (rst)
    (in_valid && elem_size == 2'd3 && idx_vec[VEC_W/2 +: 2] == 2'd3)
      |=> (result[VEC_W-1 -: VEC_W/2] == $past(src_j[VEC_W-1 -: VEC_W/2])));
endmodule

bind vsel_shuffle vsel_shuffle_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/vsel_shuffle_test.sv
`timescale 1ns/1ps
module vsel_shuffle_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [1:0]   elem_size;
  logic [127:0] src_j, src_k, idx_vec;
  logic         out_valid, out_idx_from_dest;
  logic [127:0] result;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  vsel_shuffle uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .elem_size(elem_size),
    .src_j(src_j), .src_k(src_k), .idx_vec(idx_vec),
    .out_valid(out_valid), .out_idx_from_dest(out_idx_from_dest),
    .result(result)
  );

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [127:0] model(input int sz, input logic [127:0] j,
                                         input logic [127:0] k, input logic [127:0] ix);
    logic [127:0] r;
    int ew, n, raw, kk;
    r  = '0;
    ew = 8 << sz;
    n  = 128 / ew;
    for (int i = 0; i < n; i++) begin
      raw = int'(ix[i*ew +: 8]);
      kk  = raw % (2 * n);
      for (int b = 0; b < ew; b++)
        r[i*ew + b] = (kk < n) ? k[kk*ew + b] : j[(kk - n)*ew + b];
    end
    return r;
  endfunction

  function automatic string req_of(input int sz);
    case (sz)
      0: return "R7/R4/R5/R6";
      1: return "R8/R4/R5/R6";
      2: return "R9/R4/R5/R6";
      default: return "R10/R4/R5/R6";
    endcase
  endfunction

  task automatic apply(input int sz, input logic [127:0] j,
                       input logic [127:0] k, input logic [127:0] ix);
    logic [127:0] exp;
    exp = model(sz, j, k, ix);
    @(negedge clk);
    in_valid  = 1'b1;
    elem_size = 2'(sz);
    src_j = j; src_k = k; idx_vec = ix;
    @(negedge clk);
    vectors++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s size=%0d result=%h expected=%h", req_of(sz), sz, result, exp);
    end
    if (out_valid !== 1'b1) begin
      fails++;
      $display("FAIL R2 out_valid=%b expected=1", out_valid);
    end
    if (out_idx_from_dest !== (sz != 0)) begin
      fails++;
      $display("FAIL R11 out_idx_from_dest=%b expected=%b", out_idx_from_dest, sz != 0);
    end
  endtask

  task automatic idle_check();
    logic [127:0] held;
    logic         hm;
    held = result;
    hm   = out_idx_from_dest;
    in_valid = 1'b0;
    src_j = rnd128(); src_k = rnd128(); idx_vec = rnd128();
    elem_size = 2'($urandom);
    @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R2 out_valid=%b expected=0", out_valid);
    end
    if (result !== held || out_idx_from_dest !== hm) begin
      fails++;
      $display("FAIL R3 result=%h expected=%h mode=%b expected=%b",
               result, held, out_idx_from_dest, hm);
    end
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; elem_size = 2'd0;
    src_j = '1; src_k = '1; idx_vec = '1;
    repeat (3) @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || out_idx_from_dest !== 1'b0 || result !== '0) begin
      fails++;
      $display("FAIL R1 valid=%b mode=%b result=%h expected=0/0/0",
               out_valid, out_idx_from_dest, result);
    end
    rst = 1'b0;

    // Deterministic sweep: each lane's index byte walks all 256 values (R4..R10)
    for (int sz = 0; sz < 4; sz++) begin
      for (int s = 0; s < 256; s++) begin
        logic [127:0] ix;
        int ew;
        ew = 8 << sz;
        ix = rnd128();
        for (int i = 0; i < 128 / ew; i++)
          ix[i*ew +: 8] = 8'((s + i * 3) & 255);
        apply(sz, rnd128(), rnd128(), ix);
      end
      idle_check();
    end

    // Random operations with idle gaps (R2, R3)
    for (int t = 0; t < 512; t++) begin
      apply(int'($urandom % 4), rnd128(), rnd128(), rnd128());
      if (t % 16 == 0) idle_check();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule